// File: doc/BRIEF.md
# Legacy Message Interrupt Capability Unit

This block holds the configuration registers of a basic message-signalled interrupt function. It supports a 64-bit message address and per-vector masking. System software reaches the registers through a DWORD-wide configuration read/write port. The registers are the control word, the lower and upper address, the 16-bit message data, and a mask register and a pending register.

Up to 32 level-style interrupt sources feed the block. When messages are enabled, each new assertion of a source maps to an allocated vector. The block then issues one DWORD memory-write request, on a request/acknowledge handshake. A masked vector is held back in its pending bit and is sent when it is unmasked. When messages are disabled, the sources drive an active-low wired interrupt output instead.

The sender is a two-state machine. In `SND_IDLE` it picks the lowest-numbered vector that is ready, latches the address and data, and moves to `SND_BUSY` (transition *grant*). In `SND_BUSY` it holds the request until acknowledge. It then returns to `SND_IDLE` (transition *retire*) and clears the vector's ready state. With no candidate, `SND_IDLE` stays put (*idle*). Without acknowledge, `SND_BUSY` stays put (*hold*).

Top module: `msg_irq_cap`

## Requirements
- R1: After reset, DWORD index 0 reads 0x0186_0005 with the defaults. The layout of DWORD 0 is: bits 7:0 capability ID 05h, bits 15:8 next pointer, bit 16 enable, bits 19:17 requested-count code (parameter, default 3), bits 22:20 allocated-count code, bit 23 = 1 (64-bit capable), bit 24 = 1 (mask capable), all other bits 0. Mask and pending read 0, `msg_req` is low and `irq_wire_n` is high.
- R2: DWORD indices are 1 lower address, 2 upper address, 3 data, 4 mask and 5 pending; indices 6 and 7 read 0. Lower-address bits 1:0 read 0, and data bits 31:16 read 0.
- R3: A written allocated-count code above the requested code (this includes the reserved codes 110 and 111) is stored as the requested code.
- R4: For an allocated code n, the message data is the data register with its low n bits replaced by the vector number, placed in bits 15:0 of the written DWORD with bits 31:16 zero. Code 0 leaves the data unchanged.
- R5: The message address is {upper, lower[31:2], 2'b00}. `msg_wide` is 1 exactly when the upper address is nonzero.
- R6: Source i raises vector (i mod 2^n), where n is the allocated code.
- R7: While enabled, a message is produced only on a low-to-high transition of a source. A source held high produces no second message.
- R8: An event on a masked vector sets its pending bit (index 5, bit = vector) and sends nothing. Clearing the mask sends the message, and the pending bit then reads 0.
- R9: Vectors ready in the same cycle are sent in ascending vector order.
- R10: While enabled, `irq_wire_n` stays high. While disabled, `irq_wire_n` is low one cycle after any source is high, and no message is produced.
- R11: Mask bits at and above 2^(requested code) read 0, whatever was written to them.
- R12: Once raised, `msg_req`, `msg_addr`, `msg_wide` and `msg_wdata` hold steady until the cycle in which `msg_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | DWORD index of the configuration access |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational from `cfg_idx`) |
| src_lvl | input | NUM_SRC | Level interrupt sources, active high |
| msg_req | output | 1 | Message write request |
| msg_ack | input | 1 | Acknowledge that retires the current request |
| msg_addr | output | 64 | Message write address |
| msg_wide | output | 1 | Address needs 64 bits (upper half nonzero) |
| msg_wdata | output | 32 | Message write DWORD |
| irq_wire_n | output | 1 | Active-low wired interrupt, used while disabled |

## Verification
A corrupted armed or pending vector shows up as a spurious or missing message. The scoreboard catches this within a few cycles of the source edge, or of the unmask write. A wrong mapping or a wrong data merge shows up in the low data bits of the very next request. A broken priority shows up as the wrong message order. A latch that fails to hold shows up in the cycle after the request rises. State left behind by a wrong enable decode shows up on the wired output one cycle after a source changes.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;

    localparam logic [7:0] CAP_ID_VAL = 8'h05;

    localparam logic [2:0] IDX_CTRL    = 3'd0;
    localparam logic [2:0] IDX_ADDR_LO = 3'd1;
    localparam logic [2:0] IDX_ADDR_HI = 3'd2;
    localparam logic [2:0] IDX_DATA    = 3'd3;
    localparam logic [2:0] IDX_MASK    = 3'd4;
    localparam logic [2:0] IDX_PEND    = 3'd5;

    typedef enum logic [0:0] {
        SND_IDLE = 1'b0,
        SND_BUSY = 1'b1
    } snd_state_e;

    // low-order bit mask for a count code (0..5)
    function automatic logic [15:0] code_lowmask(input logic [2:0] code);
        logic [16:0] m;
        m = (17'd1 << code) - 17'd1;
        return m[15:0];
    endfunction

endpackage

// File: rtl/msg_irq_regs.sv
module msg_irq_regs
    import msg_irq_pkg::*;
#(
    parameter int NVEC     = 8,
    parameter int REQ_CODE = 3,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [2:0]      cfg_idx,
    input  logic [31:0]     cfg_wdata,
    input  logic [NVEC-1:0] pend_i,
    output logic [31:0]     cfg_rdata,
    output logic            en_o,
    output logic [2:0]      alloc_o,
    output logic [31:2]     addr_lo_o,
    output logic [31:0]     addr_hi_o,
    output logic [15:0]     data_o,
    output logic [NVEC-1:0] mask_o
);

    localparam logic [2:0] REQ_C = 3'(REQ_CODE);

    logic            en_q;
    logic [2:0]      alloc_q;
    logic [31:2]     lo_q;
    logic [31:0]     hi_q;
    logic [15:0]     data_q;
    logic [NVEC-1:0] mask_q;
    logic [2:0]      alloc_wr;

    assign alloc_wr = (cfg_wdata[22:20] > REQ_C) ? REQ_C : cfg_wdata[22:20];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            alloc_q <= 3'd0;
            lo_q    <= '0;
            hi_q    <= '0;
            data_q  <= '0;
            mask_q  <= '0;
        end else if (cfg_wr) begin
            case (cfg_idx)
                IDX_CTRL: begin
                    en_q    <= cfg_wdata[16];
                    alloc_q <= alloc_wr;
                end
                IDX_ADDR_LO: lo_q   <= cfg_wdata[31:2];
                IDX_ADDR_HI: hi_q   <= cfg_wdata;
                IDX_DATA:    data_q <= cfg_wdata[15:0];
                IDX_MASK:    mask_q <= cfg_wdata[NVEC-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_idx)
            IDX_CTRL: begin
                cfg_rdata[7:0]   = CAP_ID_VAL;
                cfg_rdata[15:8]  = NEXT_PTR;
                cfg_rdata[16]    = en_q;
                cfg_rdata[19:17] = REQ_C;
                cfg_rdata[22:20] = alloc_q;
                cfg_rdata[23]    = 1'b1;
                cfg_rdata[24]    = 1'b1;
            end
            IDX_ADDR_LO: cfg_rdata[31:2]     = lo_q;
            IDX_ADDR_HI: cfg_rdata           = hi_q;
            IDX_DATA:    cfg_rdata[15:0]     = data_q;
            IDX_MASK:    cfg_rdata[NVEC-1:0] = mask_q;
            IDX_PEND:    cfg_rdata[NVEC-1:0] = pend_i;
            default:     cfg_rdata           = '0;
        endcase
    end

    assign en_o      = en_q;
    assign alloc_o   = alloc_q;
    assign addr_lo_o = lo_q;
    assign addr_hi_o = hi_q;
    assign data_o    = data_q;
    assign mask_o    = mask_q;

endmodule

// File: rtl/msg_irq_vecmap.sv
module msg_irq_vecmap #(
    parameter int NUM_SRC = 32,
    parameter int NVEC    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [2:0]         alloc,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic [NVEC-1:0]    hit,
    output logic               any_lvl
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] rise;
    logic [4:0]         amask;
    logic [5:0]         amask6;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src_lvl;
    end

    assign rise    = src_lvl & ~src_q & {NUM_SRC{en}};
    assign amask6  = (6'd1 << alloc) - 6'd1;
    assign amask   = amask6[4:0];
    assign any_lvl = |src_lvl;

    // source i lands on vector (i mod allocated count)
    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        always_comb begin
            hit[v] = 1'b0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if ((5'(i) & amask) == 5'(v)) hit[v] = hit[v] | rise[i];
            end
        end
    end

endmodule

// File: rtl/msg_irq_sender.sv
module msg_irq_sender
    import msg_irq_pkg::*;
#(
    parameter int NVEC = 8,
    parameter int VW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [NVEC-1:0] hit,
    input  logic [NVEC-1:0] mask,
    input  logic [2:0]      alloc,
    input  logic [31:2]     addr_lo,
    input  logic [31:0]     addr_hi,
    input  logic [15:0]     data,
    input  logic            msg_ack,
    output logic [NVEC-1:0] pend,
    output logic            msg_req,
    output logic [63:0]     msg_addr,
    output logic            msg_wide,
    output logic [31:0]     msg_wdata
);

    snd_state_e state_q, state_d;

    logic [NVEC-1:0] armed_q, pend_q;
    logic [NVEC-1:0] cand, clr;
    logic [VW-1:0]   vec_q, sel;
    logic            found;
    logic [63:0]     addr_q;
    logic            wide_q;
    logic [31:0]     wdata_q;
    logic [15:0]     lm;
    logic            grant, retire;

    assign cand = (armed_q | pend_q) & ~mask & {NVEC{en}};

    // lowest-numbered candidate wins
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int v = NVEC - 1; v >= 0; v--) begin
            if (cand[v]) begin
                sel   = VW'(v);
                found = 1'b1;
            end
        end
    end

    assign grant  = (state_q == SND_IDLE) && found;
    assign retire = (state_q == SND_BUSY) && msg_ack;

    always_comb begin
        for (int v = 0; v < NVEC; v++) clr[v] = retire && (vec_q == VW'(v));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SND_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SND_IDLE: if (found)   state_d = SND_BUSY;
            SND_BUSY: if (msg_ack) state_d = SND_IDLE;
        endcase
    end

    // armed / pending vectors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= '0;
            pend_q  <= '0;
        end else begin
            armed_q <= en ? ((armed_q & ~mask & ~clr) | (hit & ~mask)) : '0;
            pend_q  <= (pend_q & ~clr) | (hit & mask) | (armed_q & mask & ~clr);
        end
    end

    assign lm = code_lowmask(alloc);

    // output latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q   <= '0;
            addr_q  <= '0;
            wide_q  <= 1'b0;
            wdata_q <= '0;
        end else if (grant) begin
            vec_q   <= sel;
            addr_q  <= {addr_hi, addr_lo, 2'b00};
            wide_q  <= (addr_hi != 32'h0);
            wdata_q <= {16'h0, (data & ~lm) | (16'(sel) & lm)};
        end
    end

    assign msg_req   = (state_q == SND_BUSY);
    assign msg_addr  = addr_q;
    assign msg_wide  = wide_q;
    assign msg_wdata = wdata_q;
    assign pend      = pend_q;

endmodule

// File: rtl/msg_irq_cap.sv
module msg_irq_cap #(
    parameter int NUM_SRC  = 32,
    parameter int REQ_CODE = 3,
    parameter logic [7:0] NEXT_PTR = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [2:0]         cfg_idx,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic               msg_req,
    input  logic               msg_ack,
    output logic [63:0]        msg_addr,
    output logic               msg_wide,
    output logic [31:0]        msg_wdata,
    output logic               irq_wire_n
);

    localparam int NVEC = 1 << REQ_CODE;
    localparam int VW   = (NVEC > 1) ? $clog2(NVEC) : 1;

    logic            en_w;
    logic [2:0]      alloc_w;
    logic [31:2]     lo_w;
    logic [31:0]     hi_w;
    logic [15:0]     data_w;
    logic [NVEC-1:0] mask_w, pend_w, hit_w;
    logic            any_w;

    msg_irq_regs #(.NVEC(NVEC), .REQ_CODE(REQ_CODE), .NEXT_PTR(NEXT_PTR)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .pend_i(pend_w), .cfg_rdata(cfg_rdata),
        .en_o(en_w), .alloc_o(alloc_w), .addr_lo_o(lo_w), .addr_hi_o(hi_w),
        .data_o(data_w), .mask_o(mask_w)
    );

    msg_irq_vecmap #(.NUM_SRC(NUM_SRC), .NVEC(NVEC)) map_i (
        .clk(clk), .rst_n(rst_n), .en(en_w), .alloc(alloc_w),
        .src_lvl(src_lvl), .hit(hit_w), .any_lvl(any_w)
    );

    msg_irq_sender #(.NVEC(NVEC), .VW(VW)) snd_i (
        .clk(clk), .rst_n(rst_n), .en(en_w), .hit(hit_w), .mask(mask_w),
        .alloc(alloc_w), .addr_lo(lo_w), .addr_hi(hi_w), .data(data_w),
        .msg_ack(msg_ack), .pend(pend_w), .msg_req(msg_req),
        .msg_addr(msg_addr), .msg_wide(msg_wide), .msg_wdata(msg_wdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_wire_n <= 1'b1;
        else        irq_wire_n <= !(!en_w && any_w);
    end

endmodule

// File: rtl/msg_irq_cap_chk.sv
module msg_irq_cap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msg_en,
    input logic        msg_req,
    input logic        msg_ack,
    input logic [63:0] msg_addr,
    input logic        msg_wide,
    input logic [31:0] msg_wdata,
    input logic        irq_wire_n
);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req && !msg_ack |=> msg_req && $stable(msg_addr) && $stable(msg_wdata) && $stable(msg_wide));

    // R4
    data_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> msg_wdata[31:16] == 16'h0);

    // R5
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> msg_addr[1:0] == 2'b00);

    // R5
    wide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> msg_wide == (msg_addr[63:32] != 32'h0));

    // R10
    wire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_en |=> irq_wire_n);

endmodule

bind msg_irq_cap msg_irq_cap_chk chk_i (
    .clk(clk), .rst_n(rst_n), .msg_en(en_w), .msg_req(msg_req),
    .msg_ack(msg_ack), .msg_addr(msg_addr), .msg_wide(msg_wide),
    .msg_wdata(msg_wdata), .irq_wire_n(irq_wire_n)
);

// File: tb/msg_irq_cap_tb.sv
`timescale 1ns/1ps
module msg_irq_cap_tb_top;

    localparam int NS = 32;
    localparam int RC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NS-1:0] src_lvl = '0;
    logic          msg_req;
    logic          msg_ack = 1'b0;
    logic [63:0]   msg_addr;
    logic          msg_wide;
    logic [31:0]   msg_wdata;
    logic          irq_wire_n;

    int checks = 0;
    int fails  = 0;
    logic [96:0] exp_q[$];
    string       tag_q[$];

    logic [31:0] sw_lo = 0, sw_hi = 0;
    logic [15:0] sw_data = 0;
    int          sw_alloc = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    msg_irq_cap #(.NUM_SRC(NS), .REQ_CODE(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_lvl(src_lvl),
        .msg_req(msg_req), .msg_ack(msg_ack), .msg_addr(msg_addr),
        .msg_wide(msg_wide), .msg_wdata(msg_wdata), .irq_wire_n(irq_wire_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [96:0] act, input logic [96:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        cfg_idx = idx; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        cfg_idx = idx;
        #1 d = cfg_rdata;
    endtask

    // driver: push the message the requirements predict for vector v
    task automatic expect_vec(input int v, input string tag);
        logic [15:0] lm;
        logic [31:0] dw;
        logic [63:0] ad;
        lm = 16'((1 << sw_alloc) - 1);
        dw = {16'h0, (sw_data & ~lm) | (16'(v) & lm)};
        ad = {sw_hi, sw_lo[31:2], 2'b00};
        exp_q.push_back({sw_hi != 0, ad, dw});
        tag_q.push_back(tag);
    endtask

    task automatic pulse(input int i);
        @(negedge clk); src_lvl[i] = 1'b1;
        repeat (3) @(negedge clk);
        src_lvl[i] = 1'b0;
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_q.size() != 0 && n < 300) begin
            @(negedge clk); n++;
        end
        chk(exp_q.size() == 0, tag, 97'(exp_q.size()), 97'd0);
        repeat (6) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        logic [96:0] got, want;
        string t;
        forever begin
            @(negedge clk);
            if (msg_req) begin
                got = {msg_wide, msg_addr, msg_wdata};
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected message", got, 97'd0);
                end else begin
                    want = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(got == want, t, got, want);
                end
                @(negedge clk);
                chk(msg_req && ({msg_wide, msg_addr, msg_wdata} == got), "R12 request held",
                    {msg_wide, msg_addr, msg_wdata}, got);
                msg_ack = 1'b1;
                @(negedge clk);
                msg_ack = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, rv); chk(rv == 32'h0186_0005, "R1 control", 97'(rv), 97'h0186_0005);
        rd(3'd4, rv); chk(rv == 0, "R1 mask", 97'(rv), 0);
        rd(3'd5, rv); chk(rv == 0, "R1 pending", 97'(rv), 0);
        chk(!msg_req && irq_wire_n, "R1 outputs", {msg_req, irq_wire_n}, 97'b01);

        // R2 layout and read-as-zero bits
        wr(3'd1, 32'h1234_5677); sw_lo = 32'h1234_5674;
        rd(3'd1, rv); chk(rv == 32'h1234_5674, "R2 address low bits", 97'(rv), 97'h1234_5674);
        wr(3'd3, 32'hFFFF_ABC0); sw_data = 16'hABC0;
        rd(3'd3, rv); chk(rv == 32'h0000_ABC0, "R2 data width", 97'(rv), 97'hABC0);
        rd(3'd6, rv); chk(rv == 0, "R2 unused index", 97'(rv), 0);

        // R3 clamp of allocated code
        wr(3'd0, (32'd7 << 20) | (32'd1 << 16));
        rd(3'd0, rv); chk(rv[22:20] == 3'(RC), "R3 clamp", 97'(rv[22:20]), 97'(RC));
        wr(3'd0, (32'd2 << 20) | (32'd1 << 16)); sw_alloc = 2;

        // R6 mapping, R4 data merge
        expect_vec(1, "R6 src5->vec1"); pulse(5); drain("R6 drain");
        expect_vec(2, "R4 src6->vec2"); pulse(6); drain("R4 drain");
        expect_vec(2, "R6 src30->vec2"); pulse(30); drain("R6 drain");

        // R7 held source; R10 wire quiet while enabled
        expect_vec(3, "R7 first edge");
        @(negedge clk); src_lvl[3] = 1'b1;
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R7 single message", 97'(exp_q.size()), 0);
        chk(irq_wire_n == 1'b1, "R10 enabled wire", 97'(irq_wire_n), 97'd1);
        src_lvl[3] = 1'b0;
        repeat (3) @(negedge clk);
        expect_vec(3, "R7 new edge"); pulse(3); drain("R7 drain");

        // R9 ascending order
        expect_vec(1, "R9 first"); expect_vec(3, "R9 second");
        @(negedge clk); src_lvl[3] = 1'b1; src_lvl[1] = 1'b1;
        repeat (3) @(negedge clk); src_lvl[3] = 1'b0; src_lvl[1] = 1'b0;
        drain("R9 drain");

        // R5 wide address
        wr(3'd2, 32'h0000_0001); sw_hi = 32'h1;
        expect_vec(0, "R5 wide"); pulse(0); drain("R5 drain");
        wr(3'd2, 32'h0); sw_hi = 0;
        expect_vec(0, "R5 narrow"); pulse(4); drain("R5 drain");

        // R8 mask defers to pending
        wr(3'd4, 32'h4);
        pulse(2);
        repeat (6) @(negedge clk);
        rd(3'd5, rv); chk(rv == 32'h4, "R8 pending set", 97'(rv), 97'h4);
        expect_vec(2, "R8 unmask send");
        wr(3'd4, 32'h0);
        drain("R8 drain");
        rd(3'd5, rv); chk(rv == 0, "R8 pending clear", 97'(rv), 0);

        // R11 unimplemented mask bits
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, rv); chk(rv == 32'hFF, "R11 mask width", 97'(rv), 97'hFF);
        wr(3'd4, 32'h0);

        // R4 code 0 leaves data alone
        wr(3'd0, 32'd1 << 16); sw_alloc = 0;
        expect_vec(0, "R4 code0"); pulse(7); drain("R4 drain");

        // R10 disabled: wired output follows sources, no message
        wr(3'd0, 32'h0);
        @(negedge clk); src_lvl[4] = 1'b1;
        repeat (3) @(negedge clk);
        chk(irq_wire_n == 1'b0, "R10 wire asserted", 97'(irq_wire_n), 0);
        src_lvl[4] = 1'b0;
        repeat (3) @(negedge clk);
        chk(irq_wire_n == 1'b1, "R10 wire released", 97'(irq_wire_n), 97'd1);
        chk(exp_q.size() == 0, "R10 no message", 97'(exp_q.size()), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule